// File: doc/BRIEF.md
# Product-Term Cluster Logic Allocator

This block is the combinational steering fabric between the product-term array and the sixteen macrocell slices of a logic block. Each slice owns a cluster of five product terms. Every term in a cluster is either merged into that cluster's OR or handed out as a single-term control signal. The first term is always logic. The other four each have one fixed control role: clock, initialization or clock enable, initialization, and output enable. Each cluster's OR is always driven toward its own I/O cell as a fast path for narrow functions.

A slice builds its allocated sum, which feeds the macrocell XOR input, from up to four neighbouring clusters: the one below it, its own, and the two above it. A slice can also add the allocated sum of the slice four positions lower. Borrowing neighbours gives functions of up to 20 terms. Chaining through every fourth slice gives functions of up to 80 terms. Configuration is static during operation.

A cluster requested by more than one slice is an illegal configuration. In that case an error output is raised and the lowest-numbered requester keeps the cluster.

Top module: `ptc_alloc_top`

## Requirements
- R1: Term 0 of every cluster (bit `c*5+0` of `termIn`) always counts as logic, whatever its `termLogic` bit. `fastSum[c]` is the OR of all logic terms of cluster c.
- R2: A term whose `termLogic` bit is 0 (control) contributes 0 to its cluster's OR.
- R3: For cluster c, bit `c*5+1` drives `ctlClk[c]`, `c*5+2` drives `ctlInitCe[c]`, `c*5+3` drives `ctlInit[c]` and `c*5+4` drives `ctlOe[c]`, but only while the matching `termLogic` bit is 0. While that bit is 1, the control output is 0.
- R4: Bit k of `clusterPick[m*4 +: 4]` asks slice m for cluster m-1+k. A bit that names a cluster outside 0..15 is ignored: bit 0 of slice 0, bit 3 of slice 14, and bits 2 and 3 of slice 15.
- R5: `allocSum[m]` is the OR of the `fastSum` of every cluster granted to slice m, ORed with slice m's wide input when `wideEnable[m]` is 1.
- R6: When any cluster is requested by two or more slices, `cfgError` is 1 and only the lowest-numbered requesting slice receives that cluster. Otherwise `cfgError` is 0.
- R7: The wide input of slice m (m ≥ 4) is `allocSum[m-4]`. Slices 0 to 3 receive 0 whatever their `wideEnable` bit, and nothing wraps from slices 12 to 15.
- R8: `fastSum[c]` does not depend on which slice, if any, is granted cluster c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| termIn | input | 80 | Product-term values, cluster c at bits c*5 to c*5+4 |
| termLogic | input | 80 | Per-term steering: 1 = logic, 0 = control role |
| clusterPick | input | 64 | Per-slice 4-bit cluster request mask |
| wideEnable | input | 16 | Per-slice enable for the wide chain input |
| fastSum | output | 16 | Per-cluster OR toward the I/O cell |
| allocSum | output | 16 | Per-slice allocated sum toward the macrocell XOR |
| ctlClk | output | 16 | Individual clock term per slice |
| ctlInitCe | output | 16 | Individual initialization / clock-enable term per slice |
| ctlInit | output | 16 | Individual initialization term per slice |
| ctlOe | output | 16 | Individual output-enable term per slice |
| cfgError | output | 1 | Cluster requested by more than one slice |

## Verification
Conflict arbitration and wide chaining can act on the same slice at once. For example, a slice can lose a contested cluster while still passing its chained sum upward. The bench provokes this with overlapping requests next to active chains: first in directed cases, then in a long run of sparse random masks with wide enables set. Each output vector is judged against an independent model of the requirements. The checker also confirms that every cluster is granted to at most one slice, and that every high allocated sum traces back to a requested cluster or an enabled chain.

// File: rtl/ptc_alloc_pkg.sv
package ptc_alloc_pkg;
  localparam int NUM_SLICES        = 16;
  localparam int TERMS_PER_CLUSTER = 5;
  localparam int CANDIDATES        = 4;
  localparam int BORROW_BELOW      = 1;
  localparam int CHAIN_STRIDE      = 4;
  localparam int TERM_BITS         = NUM_SLICES * TERMS_PER_CLUSTER;
  localparam int PICK_BITS         = NUM_SLICES * CANDIDATES;

  // positions of control roles inside a cluster
  localparam int ROLE_CLK    = 1;
  localparam int ROLE_INITCE = 2;
  localparam int ROLE_INIT   = 3;
  localparam int ROLE_OE     = 4;

  typedef logic [NUM_SLICES-1:0] sliceVec_t;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    sliceVec_t [NUM_SLICES-1:0] grant;   // grant[slice][cluster]
    sliceVec_t                  wideOn;  // chain input accepted
    logic                       conflict;
  } allocCtl_t;
endpackage

// File: rtl/ptc_alloc_ctrl.sv
module ptc_alloc_ctrl
  import ptc_alloc_pkg::*;
(
  input  logic [PICK_BITS-1:0] clusterPick,
  input  sliceVec_t            wideEnable,
  output allocCtl_t            ctlBus
);
  always_comb begin
    ctlBus = '0;
    for (int c = 0; c < NUM_SLICES; c++) begin
      logic seen;
      seen = 1'b0;
      // lowest-numbered candidate slice first
      for (int j = 0; j < CANDIDATES; j++) begin
        int s;
        int k;
        s = c + BORROW_BELOW - (CANDIDATES - 1) + j;
        k = c - s + BORROW_BELOW;
        if (s >= 0 && s < NUM_SLICES) begin
          if (clusterPick[s*CANDIDATES + k]) begin
            if (seen) ctlBus.conflict = 1'b1;
            else      ctlBus.grant[s][c] = 1'b1;
            seen = 1'b1;
          end
        end
      end
    end
    for (int s = 0; s < NUM_SLICES; s++) begin
      ctlBus.wideOn[s] = wideEnable[s] && (s >= CHAIN_STRIDE);
    end
  end
endmodule

// File: rtl/ptc_alloc_datapath.sv
module ptc_alloc_datapath
  import ptc_alloc_pkg::*;
(
  input  logic [TERM_BITS-1:0] termIn,
  input  logic [TERM_BITS-1:0] termLogic,
  input  sliceVec_t [NUM_SLICES-1:0] grant,
  input  sliceVec_t            wideOn,
  output sliceVec_t            fastSum,
  output sliceVec_t            allocSum,
  output sliceVec_t            ctlClk,
  output sliceVec_t            ctlInitCe,
  output sliceVec_t            ctlInit,
  output sliceVec_t            ctlOe
);
  localparam logic [TERMS_PER_CLUSTER-1:0] ALWAYS_LOGIC = TERMS_PER_CLUSTER'(1);

  for (genvar c = 0; c < NUM_SLICES; c++) begin : g_cluster
    logic [TERMS_PER_CLUSTER-1:0] terms;
    logic [TERMS_PER_CLUSTER-1:0] steer;
    logic [TERMS_PER_CLUSTER-1:0] logicTerms;
    logic [TERMS_PER_CLUSTER-1:0] ctrlTerms;
    assign terms      = termIn[c*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER];
    assign steer      = termLogic[c*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER] | ALWAYS_LOGIC;
    assign logicTerms = terms & steer;
    assign ctrlTerms  = terms & ~steer;
    assign fastSum[c]   = |logicTerms;
    assign ctlClk[c]    = ctrlTerms[ROLE_CLK];
    assign ctlInitCe[c] = ctrlTerms[ROLE_INITCE];
    assign ctlInit[c]   = ctrlTerms[ROLE_INIT];
    assign ctlOe[c]     = ctrlTerms[ROLE_OE];
  end

  // chain resolved in ascending slice order inside one process
  always_comb begin
    sliceVec_t sums;
    sums = '0;
    for (int m = 0; m < NUM_SLICES; m++) begin
      logic chainIn;
      chainIn = 1'b0;
      if (m >= CHAIN_STRIDE) chainIn = sums[m - CHAIN_STRIDE];
      sums[m] = (|(grant[m] & fastSum)) | (wideOn[m] & chainIn);
    end
    allocSum = sums;
  end
endmodule

// File: rtl/ptc_alloc_top.sv
module ptc_alloc_top
  import ptc_alloc_pkg::*;
(
  input  logic [TERM_BITS-1:0]  termIn,
  input  logic [TERM_BITS-1:0]  termLogic,
  input  logic [PICK_BITS-1:0]  clusterPick,
  input  logic [NUM_SLICES-1:0] wideEnable,
  output logic [NUM_SLICES-1:0] fastSum,
  output logic [NUM_SLICES-1:0] allocSum,
  output logic [NUM_SLICES-1:0] ctlClk,
  output logic [NUM_SLICES-1:0] ctlInitCe,
  output logic [NUM_SLICES-1:0] ctlInit,
  output logic [NUM_SLICES-1:0] ctlOe,
  output logic                  cfgError
);
  allocCtl_t ctlBus;

  ptc_alloc_ctrl ctrl_i (
    .clusterPick (clusterPick),
    .wideEnable  (wideEnable),
    .ctlBus      (ctlBus)
  );

  ptc_alloc_datapath dp_i (
    .termIn    (termIn),
    .termLogic (termLogic),
    .grant     (ctlBus.grant),
    .wideOn    (ctlBus.wideOn),
    .fastSum   (fastSum),
    .allocSum  (allocSum),
    .ctlClk    (ctlClk),
    .ctlInitCe (ctlInitCe),
    .ctlInit   (ctlInit),
    .ctlOe     (ctlOe)
  );

  assign cfgError = ctlBus.conflict;
endmodule

// File: rtl/ptc_alloc_chk.sv
module ptc_alloc_chk
  import ptc_alloc_pkg::*;
(
  input logic [TERM_BITS-1:0]  termIn,
  input logic [TERM_BITS-1:0]  termLogic,
  input logic [PICK_BITS-1:0]  clusterPick,
  input logic [NUM_SLICES-1:0] wideEnable,
  input logic [NUM_SLICES-1:0] fastSum,
  input logic [NUM_SLICES-1:0] allocSum,
  input logic [NUM_SLICES-1:0] ctlClk,
  input logic [NUM_SLICES-1:0] ctlOe,
  input logic                  cfgError,
  input sliceVec_t [NUM_SLICES-1:0] ctlGrant,
  input sliceVec_t             ctlWide
);
  for (genvar m = 0; m < NUM_SLICES; m++) begin : g_chk
    always_comb begin
      sliceVec_t column;
      sliceVec_t reach;
      logic      chainOk;
      int        reqCount;
      int        cl;
      column = '0;
      for (int s = 0; s < NUM_SLICES; s++) column[s] = ctlGrant[s][m];
      reach = '0;
      for (int k = 0; k < CANDIDATES; k++) begin
        cl = m - BORROW_BELOW + k;
        if (cl >= 0 && cl < NUM_SLICES && clusterPick[m*CANDIDATES + k]) reach[cl] = 1'b1;
      end
      chainOk = 1'b0;
      if (m >= CHAIN_STRIDE) chainOk = wideEnable[m] && allocSum[m - CHAIN_STRIDE];
      reqCount = 0;
      for (int s = m - BORROW_BELOW - 1; s <= m + BORROW_BELOW; s++) begin
        if (s >= 0 && s < NUM_SLICES && clusterPick[s*CANDIDATES + (m - s + BORROW_BELOW)])
          reqCount++;
      end

      // R6
      grant_onehot_chk: assert ($onehot0(column));
      // R6
      clean_cfg_chk: assert (cfgError || reqCount <= 1);
      // R3
      clk_source_chk: assert (!ctlClk[m] ||
        (termIn[m*TERMS_PER_CLUSTER + ROLE_CLK] && !termLogic[m*TERMS_PER_CLUSTER + ROLE_CLK]));
      // R3
      oe_source_chk: assert (!ctlOe[m] ||
        (termIn[m*TERMS_PER_CLUSTER + ROLE_OE] && !termLogic[m*TERMS_PER_CLUSTER + ROLE_OE]));
      // R2
      fast_source_chk: assert (!fastSum[m] ||
        termIn[m*TERMS_PER_CLUSTER] ||
        (|(termIn[m*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER] &
           termLogic[m*TERMS_PER_CLUSTER +: TERMS_PER_CLUSTER])));
      // R5
      alloc_source_chk: assert (!allocSum[m] || (|(reach & fastSum)) || chainOk);
      // R7
      wide_origin_chk: assert (!ctlWide[m] || (m >= CHAIN_STRIDE && wideEnable[m]));
    end
  end
endmodule

bind ptc_alloc_top ptc_alloc_chk chk_i (
  .termIn      (termIn),
  .termLogic   (termLogic),
  .clusterPick (clusterPick),
  .wideEnable  (wideEnable),
  .fastSum     (fastSum),
  .allocSum    (allocSum),
  .ctlClk      (ctlClk),
  .ctlOe       (ctlOe),
  .cfgError    (cfgError),
  .ctlGrant    (ctlBus.grant),
  .ctlWide     (ctlBus.wideOn)
);

// File: tb/ptc_alloc_top_tb_top.sv
module ptc_alloc_top_tb_top;
  localparam int NS = 16;
  localparam int TB = 80;
  localparam int PB = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [TB-1:0] termIn = '0, termLogic = '0;
  logic [PB-1:0] clusterPick = '0;
  logic [NS-1:0] wideEnable = '0;
  logic [NS-1:0] fastSum, allocSum, ctlClk, ctlInitCe, ctlInit, ctlOe;
  logic cfgError;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [NS-1:0] eFast, eAlloc, eClk, eInitCe, eInit, eOe;
  logic eErr;

  ptc_alloc_top dut_i (
    .termIn(termIn), .termLogic(termLogic), .clusterPick(clusterPick),
    .wideEnable(wideEnable), .fastSum(fastSum), .allocSum(allocSum),
    .ctlClk(ctlClk), .ctlInitCe(ctlInitCe), .ctlInit(ctlInit), .ctlOe(ctlOe),
    .cfgError(cfgError)
  );

  task automatic check(string tag, string what, logic [NS-1:0] act, logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected values from the requirements
  task automatic model();
    logic [NS-1:0] gr [NS];
    for (int s = 0; s < NS; s++) gr[s] = '0;
    eErr = 1'b0;
    for (int c = 0; c < NS; c++) begin
      logic [4:0] t, l;
      bit taken;
      t = termIn[c*5 +: 5];
      l = termLogic[c*5 +: 5];
      eFast[c]   = t[0] | (|(t[4:1] & l[4:1]));   // R1, R2
      eClk[c]    = t[1] & ~l[1];                  // R3
      eInitCe[c] = t[2] & ~l[2];
      eInit[c]   = t[3] & ~l[3];
      eOe[c]     = t[4] & ~l[4];
      taken = 1'b0;
      for (int s = c - 2; s <= c + 1; s++) begin   // R4, R6
        if (s >= 0 && s < NS && clusterPick[s*4 + (c - s + 1)]) begin
          if (taken) eErr = 1'b1; else gr[s][c] = 1'b1;
          taken = 1'b1;
        end
      end
    end
    for (int m = 0; m < NS; m++) begin             // R5, R7
      eAlloc[m] = |(gr[m] & eFast);
      if (m >= 4 && wideEnable[m]) eAlloc[m] = eAlloc[m] | eAlloc[m-4];
    end
  endtask

  task automatic settle();
    @(negedge clk);
    model();
  endtask

  task automatic checkAll(string tag);
    check(tag, "fastSum", fastSum, eFast);
    check(tag, "allocSum", allocSum, eAlloc);
    check(tag, "ctlClk", ctlClk, eClk);
    check(tag, "ctlInitCe", ctlInitCe, eInitCe);
    check(tag, "ctlInit", ctlInit, eInit);
    check(tag, "ctlOe", ctlOe, eOe);
    check(tag, "cfgError", {15'd0, cfgError}, {15'd0, eErr});
  endtask

  task automatic clearAll();
    @(posedge clk);
    termIn = '0; termLogic = '0; clusterPick = '0; wideEnable = '0;
  endtask

  task automatic test_idle();
    clearAll(); settle();
    check("R1", "idle fastSum", fastSum, '0);
    check("R5", "idle allocSum", allocSum, '0);
    checkAll("R3");
  endtask

  task automatic test_term0();
    clearAll();
    termIn[3*5] = 1'b1;                 // term 0 of cluster 3, steering bit 0
    settle();
    check("R1", "term0 always logic", fastSum, 16'h0008);
    checkAll("R1");
  endtask

  task automatic test_controls();
    clearAll();
    termIn[2*5 +: 5] = 5'b11110;
    settle();
    check("R2", "control terms excluded", fastSum, '0);
    check("R3", "clk role", ctlClk, 16'h0004);
    check("R3", "oe role", ctlOe, 16'h0004);
    checkAll("R3");
    @(posedge clk); termLogic[2*5 +: 5] = 5'b11110;
    settle();
    check("R3", "controls idle when logic", ctlInitCe | ctlInit | ctlClk | ctlOe, '0);
    check("R1", "logic terms ORed", fastSum, 16'h0004);
    checkAll("R2");
  endtask

  task automatic test_edges();
    clearAll();
    for (int c = 0; c < NS; c++) termIn[c*5] = 1'b1;
    clusterPick[0*4 +: 4]  = 4'b0001;
    clusterPick[14*4 +: 4] = 4'b1000;
    clusterPick[15*4 +: 4] = 4'b1100;
    settle();
    check("R4", "out-of-range picks ignored", allocSum, '0);
    check("R4", "no error from ignored bits", {15'd0, cfgError}, '0);
    checkAll("R4");
  endtask

  task automatic test_borrow();
    clearAll();
    termIn[7*5] = 1'b1;
    clusterPick[5*4 +: 4] = 4'b1111;    // clusters 4..7 into slice 5
    settle();
    check("R5", "borrow m+2", allocSum, 16'h0020);
    checkAll("R5");
  endtask

  task automatic test_conflict();
    clearAll();
    termIn[4*5] = 1'b1;
    clusterPick[3*4 +: 4] = 4'b0100;    // slice 3 asks cluster 4
    clusterPick[4*4 +: 4] = 4'b0010;    // slice 4 asks cluster 4
    wideEnable[7] = 1'b1;
    settle();
    check("R6", "error flag", {15'd0, cfgError}, 16'h0001);
    check("R6", "lower slice wins", allocSum, 16'h0088);
    checkAll("R6");
  endtask

  task automatic test_chain();
    clearAll();
    termIn[0] = 1'b1;
    clusterPick[0*4 +: 4] = 4'b0010;
    wideEnable = 16'h1110;
    settle();
    check("R7", "80-term chain", allocSum, 16'h1111);
    @(posedge clk); wideEnable[8] = 1'b0;
    settle();
    check("R7", "chain broken", allocSum, 16'h0011);
    clearAll();
    termIn[12*5] = 1'b1;
    clusterPick[12*4 +: 4] = 4'b0010;
    wideEnable = 16'h000F;
    settle();
    check("R7", "no wraparound", allocSum, 16'h1000);
    checkAll("R7");
  endtask

  task automatic test_fast_kept();
    clearAll();
    termIn[6*5] = 1'b1;
    clusterPick[5*4 +: 4] = 4'b0100;    // slice 5 takes cluster 6
    settle();
    check("R8", "fast path kept", fastSum, 16'h0040);
    check("R8", "borrowed sum", allocSum, 16'h0020);
    checkAll("R8");
  endtask

  task automatic test_random();
    for (int i = 0; i < 80; i++) begin
      @(posedge clk);
      termIn      = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      termLogic   = {$urandom, $urandom, $urandom};
      clusterPick = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      wideEnable  = 16'($urandom);
      settle();
      checkAll("R5");
    end
  endtask

  initial begin
    test_idle();
    test_term0();
    test_controls();
    test_edges();
    test_borrow();
    test_conflict();
    test_chain();
    test_fast_kept();
    test_random();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule